// File: doc/BRIEF.md
# Prescaled Dual-Mode Down Timer

This block is an 8-bit down-counter stepped by a 6-bit programmable prescaler. Software writes three registers: a mode register, a prescaler register and an initial-value register. It can read the live count and the mode register at any time. When the prescaler and the counter reach their end of count on the same step, the block emits a one-cycle interrupt request. In single-pass operation the count then stops at zero. In modulo-N operation the initial value is reloaded and counting goes on.

The count source is either an internal enable that pulses once per four system clocks (`tick4_i`) or an external pin. The pin passes through a two-flop synchroniser, and edges are found on the synchronised level. With the internal source the pin can act as a gate, a one-shot start trigger, or a retriggerable trigger. Parameter `HAS_EXT` builds either the full variant or an internal-only variant. In the internal-only variant the pin, the source bit and the pin-mode field have no effect.

A control state machine has three states. `ST_STOP` holds the count. `ST_ARMED` waits for a trigger edge. `ST_RUN` lets source ticks step the prescaler. The transitions are:
- STOP→RUN or STOP→ARMED on a mode write with enable set.
- ARMED→RUN on a falling edge of the synchronised pin.
- RUN→STOP at terminal count in single-pass mode.
- any→STOP on a mode write with enable clear.
- A load write re-enters RUN or ARMED, depending on the newly written pin mode.

Top module: `pdt_timer`

## Requirements
- R1: After reset the count readback, the mode readback and `irq_o` are all 0.
- R2: Prescaler register layout: bit 0 selects the count mode (1 = modulo-N), bit 1 selects the source (1 = internal), and bits 7:2 hold the divide ratio M (field value 0 means 64). With the internal source, a load followed by M·N source ticks produces `irq_o` after exactly M·N clock edges.
- R3: The initial-value register sets N in the range 1..256, and a written byte of 00h means 256. A load copies it to the counter, which reads back as the low 8 bits.
- R4: `irq_o` is high for one cycle, and only on the step where the prescaler and the counter both end. Before that step the count reads N − floor(ticks/M).
- R5: In single-pass mode the count stays at 0 after the terminal step, and no further `irq_o` follows.
- R6: In modulo-N mode the counter reloads N and continues, so `irq_o` repeats every M·N ticks.
- R7: Mode register layout: bit 0 is load, bit 1 is count enable, bits 3:2 are the pin mode (00 clock, 01 gate, 10 one-shot trigger, 11 retriggerable trigger). The mode readback returns bit 0 as 0.
- R8: Clearing count enable freezes the count and the prescaler. Setting it again without load continues from the frozen state.
- R9: When the source bit is 0, each falling edge of the synchronised pin is one tick, and `tick4_i` is ignored.
- R10: In gate mode, `tick4_i` counts only while the synchronised pin is high.
- R11: In one-shot trigger mode, counting waits for a pin falling edge. Later edges during the run are ignored.
- R12: In retriggerable mode, a falling edge during a run reloads both the counter and the prescaler, and suppresses that step's interrupt.
- R13: With `HAS_EXT` = 0, the source bit and the pin mode have no effect, and the pin-mode bits read back as 0.
- R14: A load write during a run restarts from N with a fresh prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick4_i | input | 1 | Internal count enable (system clock divided by four) |
| pin_i | input | 1 | External timer pin, asynchronous |
| wr_mode_i | input | 1 | Write strobe for the mode register |
| wr_pscl_i | input | 1 | Write strobe for the prescaler register |
| wr_init_i | input | 1 | Write strobe for the initial-value register |
| wdata_i | input | 8 | Write data |
| rd_count_o | output | 8 | Live count |
| rd_mode_o | output | 8 | Mode register readback (load bit reads 0) |
| irq_o | output | 1 | One-cycle terminal-count interrupt request |

## Verification
A sweep over divide ratios {1, 2, 3, 5, 64} and initial values {1, 2, 3, 7, 256} in single-pass mode checks four things for every pairing: the exact interrupt cycle, the count one step before terminal, the one-cycle pulse width, and that the count stays at zero afterwards. Together these separate a wrong "both ends" condition, an off-by-one prescaler, and the zero-means-maximum encodings. A modulo run checks the interrupt position on every cycle across three periods, then reloads in mid-run.

The pin modes share one stimulus: a falling edge to start, then a second pulse during the run. The one-shot and retriggerable modes are told apart by whether that second pulse moves the terminal cycle. A gated burst of known length checks that exactly that many ticks pass. External-clock pulses are counted while `tick4_i` stays high. The internal-only instance sees the same writes and must ignore the pin.

// File: rtl/pdt_pkg.sv
package pdt_pkg;

    typedef enum logic [1:0] {
        ST_STOP  = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2
    } pdt_state_e;

    typedef enum logic [1:0] {
        PIN_CLOCK     = 2'd0,
        PIN_GATE      = 2'd1,
        PIN_TRIG_ONCE = 2'd2,
        PIN_TRIG_RE   = 2'd3
    } pin_mode_e;

    // mode register fields
    localparam int MODE_LOAD_BIT = 0;
    localparam int MODE_EN_BIT   = 1;
    localparam int MODE_PIN_LSB  = 2;
    localparam int MODE_PIN_W    = 2;

    // prescaler register fields
    localparam int PS_CONT_BIT = 0;
    localparam int PS_SRC_BIT  = 1;
    localparam int PS_DIV_LSB  = 2;

endpackage

// File: rtl/pdt_pin_sync.sv
module pdt_pin_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic lvl_o,
    output logic fall_o
);
    logic s1_q, s2_q, s3_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
            s3_q <= 1'b0;
        end else begin
            s1_q <= pin_i;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    assign lvl_o  = s2_q;
    assign fall_o = s3_q & ~s2_q;

    AST_FALL_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rst_n) fall_o |-> $past(lvl_o)); // R9

endmodule

// File: rtl/pdt_prescaler.sv
module pdt_prescaler #(
    parameter int PS_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reload_i,
    input  logic [PS_W-1:0] div_i,
    input  logic            tick_i,
    output logic            wrap_o
);
    localparam logic [PS_W-1:0] PS_ONE = PS_W'(1);

    logic [PS_W-1:0] ps_q;

    assign wrap_o = tick_i && (ps_q == PS_ONE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ps_q <= '0;
        end else if (reload_i) begin
            ps_q <= div_i;
        end else if (tick_i) begin
            if (wrap_o) ps_q <= div_i;
            else        ps_q <= ps_q - PS_ONE;
        end
    end

    AST_PS_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!tick_i && !reload_i) |=> $stable(ps_q)); // R8
    AST_PS_RELOAD: assert property (@(posedge clk) disable iff (!rst_n) reload_i |=> (ps_q == $past(div_i))); // R14

endmodule

// File: rtl/pdt_downcount.sv
module pdt_downcount #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reload_i,
    input  logic [CNT_W-1:0] init_i,
    input  logic             step_i,
    input  logic             cont_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             tc_o
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    assign cnt_o = cnt_q;
    assign tc_o  = step_i && (cnt_q == CNT_ONE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (reload_i) begin
            cnt_q <= init_i;
        end else if (step_i) begin
            if (tc_o) cnt_q <= cont_i ? init_i : '0;
            else      cnt_q <= cnt_q - CNT_ONE;
        end
    end

    AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (!rst_n) reload_i |=> (cnt_o == $past(init_i))); // R3
    AST_SINGLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (tc_o && !cont_i && !reload_i) |=> (cnt_o == '0)); // R5
    AST_MODN_RELOAD: assert property (@(posedge clk) disable iff (!rst_n) (tc_o && cont_i && !reload_i) |=> (cnt_o == $past(init_i))); // R6
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!step_i && !reload_i) |=> $stable(cnt_o)); // R8

endmodule

// File: rtl/pdt_ctrl.sv
module pdt_ctrl
    import pdt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mode_wr_i,
    input  logic load_i,
    input  logic en_i,
    input  logic arm_i,
    input  logic edge_i,
    input  logic retrig_i,
    input  logic tc_i,
    input  logic cont_i,
    output logic run_o,
    output logic retrig_o
);
    pdt_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_STOP;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (mode_wr_i) begin
            if (!en_i)
                state_d = ST_STOP;
            else if (load_i || state_q == ST_STOP)
                state_d = arm_i ? ST_ARMED : ST_RUN;
            else if (state_q == ST_RUN && tc_i && !cont_i)
                state_d = ST_STOP;
        end else begin
            unique case (state_q)
                ST_STOP:  state_d = ST_STOP;
                ST_ARMED: if (edge_i) state_d = ST_RUN;
                ST_RUN:   if (tc_i && !cont_i) state_d = ST_STOP;
                default:  state_d = ST_STOP;
            endcase
        end
    end

    always_comb begin
        run_o    = (state_q == ST_RUN);
        retrig_o = (state_q == ST_RUN) && retrig_i && edge_i && !mode_wr_i;
    end

    AST_SINGLE_STOPS: assert property (@(posedge clk) disable iff (!rst_n) (state_q == ST_RUN && tc_i && !cont_i && !mode_wr_i) |=> (state_q == ST_STOP)); // R5
    AST_ARMED_WAITS: assert property (@(posedge clk) disable iff (!rst_n) (state_q == ST_ARMED && !edge_i && !mode_wr_i) |=> (state_q == ST_ARMED)); // R11
    AST_DISABLE_STOPS: assert property (@(posedge clk) disable iff (!rst_n) (mode_wr_i && !en_i) |=> (state_q == ST_STOP)); // R8

endmodule

// File: rtl/pdt_timer.sv
module pdt_timer
    import pdt_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int PS_W    = 6,
    parameter bit HAS_EXT = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick4_i,
    input  logic         pin_i,
    input  logic         wr_mode_i,
    input  logic         wr_pscl_i,
    input  logic         wr_init_i,
    input  logic [7:0]   wdata_i,
    output logic [7:0]   rd_count_o,
    output logic [7:0]   rd_mode_o,
    output logic         irq_o
);
    localparam int BUS_W = 8;
    localparam int PAD_W = BUS_W - MODE_PIN_LSB - MODE_PIN_W;

    // configuration registers
    logic [CNT_W-1:0] init_q;
    logic [PS_W-1:0]  div_q;
    logic             cont_q;
    logic             src_int_q;
    logic             en_q;
    pin_mode_e        pin_mode_q;
    logic             irq_q;

    logic pin_lvl, pin_fall;
    logic ext_src, gate_on, trig_cur, retrig_cur, arm_new;
    logic [MODE_PIN_W-1:0] pin_rb;
    logic load_wr, retrig, reload, run, src_tick, step, ps_wrap, tc;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            init_q     <= '0;
            div_q      <= '0;
            cont_q     <= 1'b0;
            src_int_q  <= 1'b0;
            en_q       <= 1'b0;
            pin_mode_q <= PIN_CLOCK;
        end else begin
            if (wr_mode_i) begin
                en_q       <= wdata_i[MODE_EN_BIT];
                pin_mode_q <= pin_mode_e'(wdata_i[MODE_PIN_LSB +: MODE_PIN_W]);
            end
            if (wr_pscl_i) begin
                cont_q    <= wdata_i[PS_CONT_BIT];
                src_int_q <= wdata_i[PS_SRC_BIT];
                div_q     <= wdata_i[PS_DIV_LSB +: PS_W];
            end
            if (wr_init_i) begin
                init_q <= wdata_i[CNT_W-1:0];
            end
        end
    end

    pdt_pin_sync u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pin_i),
        .lvl_o  (pin_lvl),
        .fall_o (pin_fall)
    );

    generate
        if (HAS_EXT) begin : g_ext
            assign ext_src    = !src_int_q;
            assign gate_on    = src_int_q && (pin_mode_q == PIN_GATE);
            assign trig_cur   = src_int_q && pin_mode_q[1];
            assign retrig_cur = src_int_q && (pin_mode_q == PIN_TRIG_RE);
            assign arm_new    = src_int_q && wdata_i[MODE_PIN_LSB + 1];
            assign pin_rb     = pin_mode_q;
        end else begin : g_int
            assign ext_src    = 1'b0;
            assign gate_on    = 1'b0;
            assign trig_cur   = 1'b0;
            assign retrig_cur = 1'b0;
            assign arm_new    = 1'b0;
            assign pin_rb     = '0;
        end
    endgenerate

    assign load_wr  = wr_mode_i && wdata_i[MODE_LOAD_BIT];
    assign reload   = load_wr || retrig;
    assign src_tick = ext_src ? pin_fall : (tick4_i && (!gate_on || pin_lvl));
    assign step     = run && src_tick && !reload;

    pdt_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_wr_i (wr_mode_i),
        .load_i    (load_wr),
        .en_i      (wdata_i[MODE_EN_BIT]),
        .arm_i     (arm_new),
        .edge_i    (trig_cur && pin_fall),
        .retrig_i  (retrig_cur),
        .tc_i      (tc),
        .cont_i    (cont_q),
        .run_o     (run),
        .retrig_o  (retrig)
    );

    pdt_prescaler #(.PS_W(PS_W)) u_ps (
        .clk      (clk),
        .rst_n    (rst_n),
        .reload_i (reload),
        .div_i    (div_q),
        .tick_i   (step),
        .wrap_o   (ps_wrap)
    );

    pdt_downcount #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .reload_i (reload),
        .init_i   (init_q),
        .step_i   (ps_wrap),
        .cont_i   (cont_q),
        .cnt_o    (cnt),
        .tc_o     (tc)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= tc;
    end

    assign irq_o      = irq_q;
    assign rd_count_o = BUS_W'(cnt);
    assign rd_mode_o  = {{PAD_W{1'b0}}, pin_rb, en_q, 1'b0};

    AST_IRQ_FROM_RUN: assert property (@(posedge clk) disable iff (!rst_n) irq_o |-> $past(run)); // R4
    AST_STOP_FREEZES: assert property (@(posedge clk) disable iff (!rst_n) (!run && !reload) |=> $stable(rd_count_o)); // R8
    AST_LOAD_RESTART: assert property (@(posedge clk) disable iff (!rst_n) load_wr |=> (rd_count_o == BUS_W'($past(init_q)))); // R14

endmodule

// File: tb/pdt_timer_tb.sv
`timescale 1ns/1ps
module pdt_timer_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick4 = 1'b1;
    logic pin = 1'b0;
    logic wr_mode = 1'b0, wr_pscl = 1'b0, wr_init = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] cnt, mode_rb, cnt_b, mode_rb_b;
    logic irq, irq_b;
    int total = 0;
    int bad = 0;
    int ic = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pdt_timer dut_i (
        .clk(clk), .rst_n(rst_n), .tick4_i(tick4), .pin_i(pin),
        .wr_mode_i(wr_mode), .wr_pscl_i(wr_pscl), .wr_init_i(wr_init),
        .wdata_i(wdata), .rd_count_o(cnt), .rd_mode_o(mode_rb), .irq_o(irq)
    );

    pdt_timer #(.HAS_EXT(1'b0)) dut_int_i (
        .clk(clk), .rst_n(rst_n), .tick4_i(tick4), .pin_i(pin),
        .wr_mode_i(wr_mode), .wr_pscl_i(wr_pscl), .wr_init_i(wr_init),
        .wdata_i(wdata), .rd_count_o(cnt_b), .rd_mode_o(mode_rb_b), .irq_o(irq_b)
    );

    always @(posedge clk) if (irq) ic <= ic + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // sel: 0 mode, 1 prescaler, 2 initial value; write lands on the next rising edge
    task automatic wr(input int sel, input logic [7:0] d);
        wdata   = d;
        wr_mode = (sel == 0);
        wr_pscl = (sel == 1);
        wr_init = (sel == 2);
        @(negedge clk);
        wr_mode = 1'b0;
        wr_pscl = 1'b0;
        wr_init = 1'b0;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic run_single(input int mf, input int nb);
        int m, n, snap;
        m = (mf == 0) ? 64 : mf;
        n = (nb == 0) ? 256 : nb;
        wr(1, 8'((mf << 2) | 2));
        wr(2, 8'(nb));
        wr(0, 8'h03);
        step(m * n - 1);
        chk(irq == 1'b0, "R4 no irq before both end", int'(irq), 0);
        chk(cnt == 8'd1, "R4 count one step before end", int'(cnt), 1);
        step(1);
        chk(irq == 1'b1, "R2 irq after M*N ticks", int'(irq), 1);
        chk(cnt == 8'd0, "R5 count at zero", int'(cnt), 0);
        step(1);
        chk(irq == 1'b0, "R4 one-cycle pulse", int'(irq), 0);
        snap = ic;
        step(70);
        chk(cnt == 8'd0, "R5 count stays zero", int'(cnt), 0);
        chk(ic == snap, "R5 no further irq", ic - snap, 0);
    endtask

    task automatic pin_pulse();
        pin = 1'b1; step(2);
        pin = 1'b0; step(2);
    endtask

    initial begin
        int mlist [5] = '{1, 2, 3, 5, 0};
        int nlist [5] = '{1, 2, 3, 7, 0};
        int snap;
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        chk(cnt == 8'd0, "R1 count after reset", int'(cnt), 0);
        chk(mode_rb == 8'd0, "R1 mode after reset", int'(mode_rb), 0);
        chk(irq == 1'b0, "R1 irq after reset", int'(irq), 0);
        chk(cnt_b == 8'd0, "R1 internal-only count after reset", int'(cnt_b), 0);

        // R2 R3 R4 R5 sweep of ratio and initial value, single pass
        foreach (mlist[i]) foreach (nlist[j]) run_single(mlist[i], nlist[j]);

        // R3 initial 00h reads as 0 and means 256
        wr(1, 8'h06); wr(2, 8'h00); wr(0, 8'h03);
        chk(cnt == 8'd0, "R3 00h loads as 256 (reads 0)", int'(cnt), 0);
        step(1);
        chk(cnt == 8'd255, "R3 first step from 256", int'(cnt), 255);

        // R6 modulo-N: M=3 N=5, irq every 15 ticks
        wr(1, 8'h0F); wr(2, 8'd5); wr(0, 8'h03);
        for (int k = 1; k <= 45; k++) begin
            step(1);
            chk(irq == ((k % 15) == 0), "R6 periodic irq", int'(irq), int'((k % 15) == 0));
        end
        // R14 load in mid-run restarts the period
        wr(0, 8'h03);
        chk(cnt == 8'd5, "R14 reload count", int'(cnt), 5);
        for (int k = 1; k <= 15; k++) begin
            step(1);
            chk(irq == (k == 15), "R14 irq after restart", int'(irq), int'(k == 15));
        end

        // R7 R8 enable pause: M=2 N=4
        wr(1, 8'h0A); wr(2, 8'd4); wr(0, 8'h03);
        chk(mode_rb == 8'h02, "R7 load bit reads 0", int'(mode_rb), 2);
        step(3);
        wr(0, 8'h00);
        chk(cnt == 8'd2, "R8 count at pause", int'(cnt), 2);
        snap = ic;
        step(10);
        chk(cnt == 8'd2, "R8 count frozen", int'(cnt), 2);
        chk(ic == snap, "R8 no irq while frozen", ic - snap, 0);
        wr(0, 8'h02);
        step(3);
        chk(irq == 1'b0, "R8 not yet after resume", int'(irq), 0);
        step(1);
        chk(irq == 1'b1, "R8 irq after remaining ticks", int'(irq), 1);

        // R9 external clock, M=1 N=3; R13 internal-only instance counts tick4
        pin = 1'b0;
        wr(1, 8'h04); wr(2, 8'd3); wr(0, 8'h03);
        step(5);
        chk(cnt == 8'd3, "R9 tick4 ignored on external source", int'(cnt), 3);
        chk(cnt_b == 8'd0, "R13 internal-only ignores source bit", int'(cnt_b), 0);
        pin_pulse(); pin_pulse(); step(2);
        chk(cnt == 8'd1, "R9 two pin edges counted", int'(cnt), 1);
        snap = ic;
        pin_pulse(); step(4);
        chk(cnt == 8'd0, "R9 third edge ends count", int'(cnt), 0);
        chk(ic == snap + 1, "R9 one irq", ic - snap, 1);

        // R10 gate mode, M=1 N=10
        wr(1, 8'h06); wr(2, 8'd10); wr(0, 8'h07);
        chk(mode_rb == 8'h06, "R7 mode readback gate", int'(mode_rb), 6);
        chk(mode_rb_b == 8'h02, "R13 pin bits read 0", int'(mode_rb_b), 2);
        step(10);
        chk(cnt == 8'd10, "R10 no count with pin low", int'(cnt), 10);
        pin = 1'b1; step(3);
        pin = 1'b0; step(5);
        chk(cnt == 8'd7, "R10 three gated ticks", int'(cnt), 7);

        // R11 one-shot trigger, M=2 N=3
        pin = 1'b1; step(4);
        wr(1, 8'h0A); wr(2, 8'd3); wr(0, 8'h0B);
        step(5);
        chk(cnt == 8'd3, "R11 waits for trigger", int'(cnt), 3);
        pin = 1'b0; step(5);
        chk(cnt == 8'd2, "R11 counting after edge", int'(cnt), 2);
        pin = 1'b1; step(1);
        pin = 1'b0; step(2);
        chk(irq == 1'b0, "R11 no early irq", int'(irq), 0);
        step(1);
        chk(irq == 1'b1, "R11 second edge ignored", int'(irq), 1);
        chk(cnt == 8'd0, "R11 count ended", int'(cnt), 0);

        // R12 retriggerable, same stimulus
        pin = 1'b1; step(4);
        wr(1, 8'h0A); wr(2, 8'd3); wr(0, 8'h0F);
        step(5);
        pin = 1'b0; step(5);
        chk(cnt == 8'd2, "R12 counting after edge", int'(cnt), 2);
        pin = 1'b1; step(1);
        pin = 1'b0; step(3);
        chk(irq == 1'b0, "R12 retrigger suppresses irq", int'(irq), 0);
        chk(cnt == 8'd3, "R12 retrigger reloads", int'(cnt), 3);
        step(5);
        chk(irq == 1'b0, "R12 no irq before full count", int'(irq), 0);
        step(1);
        chk(irq == 1'b1, "R12 irq after reload period", int'(irq), 1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule